// File: doc/BRIEF.md
# IO address window classifier

This block is the first stage of an IO translation unit. Each cycle it may take one DMA address and decide where that address goes. The address can pass through to memory unchanged. It can go on to the page-table translation stage. Or it can be refused because it lies at or above a programmed address cap. The decision is registered and appears one cycle after the request, together with a copy of the address.

The window that separates pass-through from translation is set by two bounds, each counted in coarse units. The unit is 256 MB, or 4 MB when the build parameter selects fine units. The lower bound is stored as the base unit minus one, while the upper bound is stored as the top unit itself. A polarity bit swaps the meaning of the window. Normally the window passes through and everything else is translated. With the bit set, the window is translated and everything outside it passes.

The block also takes the outcome of each page-table lookup, which comes back from the later stage. From that outcome, and from the cap check, it keeps three sticky fault flags. Each cause has its own abort enable, and the cap and write causes also have interrupt enables.

Top module: `io_window_classifier`

## Requirements
- R1: After reset, `fault_flags` is 0 and `route_vld`, `abort` and `irq` are low. With every register at 0, any request is routed to translation (route code 01).
- R2: With the cap enabled (bit 31 of register 1, value V in bits [ADDR_W-29:0]), a request at or above (V+1)×256 MB is routed as a fault (code 10), and the cap flag (`fault_flags[0]`) is set. A request one byte below that limit is not a fault.
- R3: With the cap enable clear, no request is routed as a fault, whatever its address.
- R4: With both bypass enables set (bit 31 of register 2 and bit 31 of register 3) and the polarity bit (bit 30 of register 2) clear, a request whose unit index u satisfies S < u < E passes through (code 00). S is the value in register 2 and E the value in register 3. Any other request is translated (code 01).
- R5: With the polarity bit set, requests inside that same unit range are translated, and requests below or above it pass through.
- R6: If either bypass enable is clear, every request that is not a cap fault is translated.
- R7: `route_vld` is high exactly in the cycle after a cycle with `req_vld` high, and `route_addr` then equals the address that was presented.
- R8: The fault flags are sticky. Writing register 0 with a 1 in bit i (i = 0 cap, 1 invalid entry, 2 write) clears flag i, and a 0 in that bit leaves it alone. If a new event arrives in the same cycle as the clear, the flag stays set.
- R9: A lookup result whose entry is not valid sets `fault_flags[1]`.
- R10: A write whose lookup returns a valid entry without the writable bit sets `fault_flags[2]`. A read of such an entry sets nothing, and neither does a write to a writable entry.
- R11: `abort` pulses for one cycle, one cycle after an event whose cause has its abort enable set (register 0 bits 4, 5, 6 for cap, invalid, write). A cause without its enable still sets its flag but gives no abort.
- R12: `irq` is high while the cap flag is set with register 0 bit 8 set, or while the write flag is set with register 0 bit 9 set. The invalid-entry flag never raises `irq`.
- R13: Events of different causes in the same cycle set all of their flags together.
- R14: With `FINE_UNIT`=1 the bypass unit is 4 MB, so window bounds resolve at 4 MB granularity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control/flags, 1 cap, 2 window low, 3 window high |
| wr_data | input | 32 | Register write data |
| req_vld | input | 1 | Address request valid |
| req_addr | input | ADDR_W | Incoming DMA address |
| xlt_vld | input | 1 | Lookup result valid |
| xlt_pte_valid | input | 1 | Returned entry is valid |
| xlt_pte_wr | input | 1 | Returned entry is writable |
| xlt_write | input | 1 | Access that caused the lookup is a write |
| route_vld | output | 1 | Routing decision valid |
| route | output | 2 | 00 pass through, 01 translate, 10 cap fault |
| route_addr | output | ADDR_W | Address the decision belongs to |
| fault_flags | output | 3 | Sticky flags: [0] cap, [1] invalid entry, [2] write |
| abort | output | 1 | One-cycle abort pulse |
| irq | output | 1 | Interrupt level |

## Verification
The bench builds two instances with ADDR_W=36, which is wide enough to hold a 40 GB to 42 GB window and its cap. One instance uses FINE_UNIT=0 (256 MB units). At that size the cap limit and both window edges can be probed exactly one byte on either side. The other instance uses FINE_UNIT=1 (4 MB units). There, a window base moved by a single 4 MB unit is separated from its neighbour, which the coarse build cannot express.

// File: rtl/io_window_classifier.sv
module io_window_classifier #(
  parameter int ADDR_W       = 36,
  parameter int CAP_SHIFT    = 28,
  parameter int COARSE_SHIFT = 28,
  parameter int FINE_SHIFT   = 22,
  parameter bit FINE_UNIT    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [31:0]       wr_data,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              xlt_vld,
  input  logic              xlt_pte_valid,
  input  logic              xlt_pte_wr,
  input  logic              xlt_write,
  output logic              route_vld,
  output logic [1:0]        route,
  output logic [ADDR_W-1:0] route_addr,
  output logic [2:0]        fault_flags,
  output logic              abort,
  output logic              irq
);
  localparam int US = FINE_UNIT ? FINE_SHIFT : COARSE_SHIFT;
  localparam int UW = ADDR_W - US;
  localparam int CW = ADDR_W - CAP_SHIFT;
  localparam logic [1:0] RT_PASS = 2'b00, RT_XLT = 2'b01, RT_FAULT = 2'b10;

  logic          cap_en, bs_en, bs_inv, be_en;
  logic [CW-1:0] cap_val;
  logic [UW-1:0] bs_val, be_val;
  logic [2:0]    abt_en;
  logic [1:0]    irq_en;

  logic [UW-1:0] unit;
  logic          cap_hit, in_win, win_on;
  logic [1:0]    route_d;
  logic [2:0]    ev, clr;

  assign unit    = req_addr[ADDR_W-1:US];
  assign cap_hit = cap_en && (req_addr[ADDR_W-1:CAP_SHIFT] > cap_val);
  assign in_win  = (unit > bs_val) && (unit < be_val);
  assign win_on  = bs_en && be_en;
  assign route_d = cap_hit ? RT_FAULT :
                   (win_on && (in_win ^ bs_inv)) ? RT_PASS : RT_XLT;

  assign ev[0] = req_vld && cap_hit;
  assign ev[1] = xlt_vld && !xlt_pte_valid;
  assign ev[2] = xlt_vld && xlt_pte_valid && xlt_write && !xlt_pte_wr;
  assign clr   = (wr_en && wr_sel == 2'd0) ? wr_data[2:0] : 3'b000;

  assign irq = (fault_flags[0] && irq_en[0]) || (fault_flags[2] && irq_en[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_en  <= 1'b0;
      cap_val <= '0;
      bs_en   <= 1'b0;
      bs_inv  <= 1'b0;
      bs_val  <= '0;
      be_en   <= 1'b0;
      be_val  <= '0;
      abt_en  <= '0;
      irq_en  <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'd0: begin
          abt_en <= wr_data[6:4];
          irq_en <= wr_data[9:8];
        end
        2'd1: begin
          cap_en  <= wr_data[31];
          cap_val <= wr_data[CW-1:0];
        end
        2'd2: begin
          bs_en  <= wr_data[31];
          bs_inv <= wr_data[30];
          bs_val <= wr_data[UW-1:0];
        end
        default: begin
          be_en  <= wr_data[31];
          be_val <= wr_data[UW-1:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_vld   <= 1'b0;
      route       <= RT_XLT;
      route_addr  <= '0;
      fault_flags <= '0;
      abort       <= 1'b0;
    end else begin
      route_vld   <= req_vld;
      if (req_vld) begin
        route      <= route_d;
        route_addr <= req_addr;
      end
      fault_flags <= (fault_flags & ~clr) | ev;
      abort       <= |(ev & abt_en);
    end
  end
endmodule

module io_window_classifier_chk #(
  parameter int ADDR_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [31:0]       wr_data,
  input logic              req_vld,
  input logic              route_vld,
  input logic [1:0]        route,
  input logic [ADDR_W-1:0] route_addr,
  input logic [2:0]        fault_flags,
  input logic              abort,
  input logic              irq
);
  logic [2:0] clr_m;
  assign clr_m = (wr_en && wr_sel == 2'd0) ? wr_data[2:0] : 3'b000;

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
    req_vld |=> route_vld);
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !req_vld |=> !route_vld);
  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (fault_flags != 3'b000) |=> ((($past(fault_flags) & ~$past(clr_m)) & ~fault_flags) == 3'b000));
  p_fault_flags_cap_r2: assert property (@(posedge clk) disable iff (rst)
    (route_vld && route == 2'b10) |-> fault_flags[0]);
  p_abort_has_cause_r11: assert property (@(posedge clk) disable iff (rst)
    abort |-> (fault_flags != 3'b000));
  p_irq_source_r12: assert property (@(posedge clk) disable iff (rst)
    irq |-> (fault_flags[0] || fault_flags[2]));
  p_route_code_r2: assert property (@(posedge clk) disable iff (rst)
    route_vld |-> (route != 2'b11));
endmodule

bind io_window_classifier io_window_classifier_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .req_vld(req_vld), .route_vld(route_vld), .route(route),
  .route_addr(route_addr), .fault_flags(fault_flags), .abort(abort), .irq(irq)
);

// File: tb/io_window_classifier_tb.sv
module io_window_classifier_tb;
  localparam int AW = 36;
  localparam logic [AW-1:0] G40 = 36'hA_0000_0000;
  localparam logic [AW-1:0] G42 = 36'hA_8000_0000;
  localparam logic [AW-1:0] M4  = 36'h0_0040_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0; logic [1:0] wr_sel = 0; logic [31:0] wr_data = 0;
  logic req_vld = 0; logic [AW-1:0] req_addr = 0;
  logic xlt_vld = 0, xlt_pte_valid = 0, xlt_pte_wr = 0, xlt_write = 0;
  logic route_vld, abort, irq; logic [1:0] route; logic [AW-1:0] route_addr; logic [2:0] fault_flags;
  logic f_vld, f_abort, f_irq; logic [1:0] f_route; logic [AW-1:0] f_addr; logic [2:0] f_flags;
  int checks = 0, failures = 0;
  logic [31:0] en_bits = 0;

  always #10 clk = ~clk;

  io_window_classifier #(.ADDR_W(AW), .FINE_UNIT(1'b0)) u_dut (
    .clk, .rst, .wr_en, .wr_sel, .wr_data, .req_vld, .req_addr,
    .xlt_vld, .xlt_pte_valid, .xlt_pte_wr, .xlt_write,
    .route_vld, .route, .route_addr, .fault_flags, .abort, .irq);

  io_window_classifier #(.ADDR_W(AW), .FINE_UNIT(1'b1)) u_fine (
    .clk, .rst, .wr_en, .wr_sel, .wr_data, .req_vld, .req_addr,
    .xlt_vld, .xlt_pte_valid, .xlt_pte_wr, .xlt_write,
    .route_vld(f_vld), .route(f_route), .route_addr(f_addr),
    .fault_flags(f_flags), .abort(f_abort), .irq(f_irq));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ctl(logic [2:0] w1c);
    wr(2'd0, en_bits | {29'd0, w1c});
  endtask

  task automatic req(logic [AW-1:0] a);
    @(negedge clk); req_vld = 1; req_addr = a;
    @(negedge clk); req_vld = 0;
  endtask

  task automatic req_chk(string tag, logic [AW-1:0] a, logic [1:0] exp);
    req(a);
    chk({tag, " route"}, route, exp);
    chk({tag, " vld"}, route_vld, 1);
    chk({tag, " addr"}, route_addr, a);
  endtask

  task automatic xlt(logic v, logic w, logic wrt);
    @(negedge clk); xlt_vld = 1; xlt_pte_valid = v; xlt_pte_wr = w; xlt_write = wrt;
    @(negedge clk); xlt_vld = 0;
  endtask

  task automatic t_reset;
    chk("R1 flags", fault_flags, 0);
    chk("R1 vld", route_vld, 0);
    chk("R1 abort", abort, 0);
    chk("R1 irq", irq, 0);
    req_chk("R1 default translate", G42, 2'b01);
    @(negedge clk); chk("R7 vld drops", route_vld, 0);
  endtask

  task automatic t_invert_window;
    wr(2'd1, 32'h8000_00A7);
    wr(2'd2, 32'hC000_0000 | 32'd159);
    wr(2'd3, 32'h8000_0000 | 32'd168);
    req_chk("R5 below pass", G40 - 1, 2'b00);
    req_chk("R5 zero pass", 0, 2'b00);
    req_chk("R5 base translate", G40, 2'b01);
    req_chk("R5 top-1 translate", G42 - 1, 2'b01);
    req_chk("R2 at cap fault", G42, 2'b10);
    chk("R2 flag", fault_flags, 3'b001);
    chk("R11 no abort without enable", abort, 0);
    ctl(3'b001);
    chk("R8 cleared", fault_flags, 0);
  endtask

  task automatic t_plain_window;
    wr(2'd2, 32'h8000_0000 | 32'd159);
    req_chk("R4 inside pass", G40, 2'b00);
    req_chk("R4 top-1 pass", G42 - 1, 2'b00);
    req_chk("R4 below translate", G40 - 1, 2'b01);
    wr(2'd1, 32'h0000_00A7);
    req_chk("R3 cap off no fault", G42, 2'b01);
    req_chk("R3 cap off high", 36'hF_FFFF_FFFF, 2'b01);
    chk("R3 no flag", fault_flags, 0);
    wr(2'd3, 32'd168);
    req_chk("R6 end disabled", G40, 2'b01);
    wr(2'd3, 32'h8000_0000 | 32'd168);
    wr(2'd2, 32'd159);
    req_chk("R6 start disabled", G40, 2'b01);
  endtask

  task automatic t_cap_faults;
    wr(2'd1, 32'h8000_00A7);
    en_bits = 32'h0000_0010;
    ctl(3'b000);
    req(G42);
    chk("R11 abort pulse", abort, 1);
    chk("R2 flag set", fault_flags, 3'b001);
    chk("R12 irq off", irq, 0);
    @(negedge clk);
    chk("R11 abort one cycle", abort, 0);
    en_bits = 32'h0000_0110;
    ctl(3'b010);
    chk("R8 w1c zero bit no effect", fault_flags, 3'b001);
    chk("R12 cap irq", irq, 1);
    @(negedge clk); req_vld = 1; req_addr = G42; wr_en = 1; wr_sel = 0; wr_data = en_bits | 32'd1;
    @(negedge clk); req_vld = 0; wr_en = 0;
    chk("R8 set wins over clear", fault_flags, 3'b001);
    ctl(3'b001);
    chk("R8 clear", fault_flags, 0);
    chk("R12 irq drops", irq, 0);
  endtask

  task automatic t_lookup;
    xlt(0, 0, 0);
    chk("R9 invalid flag", fault_flags, 3'b010);
    chk("R11 no abort invalid", abort, 0);
    chk("R12 invalid no irq", irq, 0);
    ctl(3'b010);
    xlt(1, 0, 0);
    chk("R10 read no flag", fault_flags, 0);
    xlt(1, 1, 1);
    chk("R10 writable no flag", fault_flags, 0);
    en_bits = 32'h0000_0240;
    ctl(3'b000);
    xlt(1, 0, 1);
    chk("R10 write violation", fault_flags, 3'b100);
    chk("R11 write abort", abort, 1);
    chk("R12 write irq", irq, 1);
    ctl(3'b100);
    en_bits = 32'h0000_0020;
    ctl(3'b000);
    @(negedge clk); req_vld = 1; req_addr = G42;
    xlt_vld = 1; xlt_pte_valid = 0; xlt_pte_wr = 0; xlt_write = 0;
    @(negedge clk); req_vld = 0; xlt_vld = 0;
    chk("R13 both flags", fault_flags, 3'b011);
    chk("R13 abort from invalid", abort, 1);
    chk("R13 route fault", route, 2'b10);
    ctl(3'b111);
  endtask

  task automatic t_fine;
    wr(2'd1, 32'd0);
    wr(2'd2, 32'hC000_0000 | 32'd10240);
    wr(2'd3, 32'h8000_0000 | 32'd10752);
    req(G40 + M4 - 1);
    chk("R14 fine below pass", f_route, 2'b00);
    req(G40 + M4);
    chk("R14 fine base translate", f_route, 2'b01);
    req(G42 - 1);
    chk("R14 fine top-1 translate", f_route, 2'b01);
    req(G42);
    chk("R14 fine above pass", f_route, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_invert_window;
    t_plain_window;
    t_cap_faults;
    t_lookup;
    t_fine;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule